// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a sticky record of why the processor last restarted or woke up. It also tells the core where to resume execution. Every restart, trap or wake source delivers a one-cycle pulse. Each pulse sets, clears or keeps each of nine status flags by its own rule, so causes that came before survive as history until software clears them. Two qualifier inputs report whether the core was sleeping or idling when the external reset pin fired.

Software reads all nine flags at once on `status` and can overwrite them through a single write strobe. Alongside the flags, the block raises `resume_valid` with a two-bit `resume_sel` code. The code is held until the core acknowledges it. When several sources pulse in the same cycle, only the highest-priority one takes effect.

Top module: `rcs_top`

## Requirements
- R1: Flag bit positions on `status` and `wr_data` are: 0 power-on, 1 brown-out, 2 external pin, 3 software, 4 watchdog time-out, 5 sleep, 6 idle, 7 trap conflict, 8 illegal operation. A `wr_en` pulse with no event in that cycle loads `wr_data` into the flags, visible on the next cycle.
- R2: Power-on sets the power-on and brown-out flags and clears the other seven (status = 0x003).
- R3: Brown-out sets the brown-out flag, clears the power-on flag and keeps the rest.
- R4: An external pin reset sets the pin flag and clears the watchdog flag. It loads sleep from `core_sleep` and idle from `core_idle`. It clears the software flag only when neither qualifier is high, and it keeps the trap, illegal, power-on and brown-out flags.
- R5: A software reset sets the software flag, clears the pin, watchdog, idle and sleep flags, and keeps the rest.
- R6: A watchdog time-out sets the watchdog flag, clears the pin, software, idle and sleep flags, and keeps the rest.
- R7: A watchdog wake sets the watchdog and sleep flags, keeps the rest, and selects resume code 2 (PC+2).
- R8: An interrupt wake sets only the sleep flag. It selects code 3 (interrupt vector) when `int_enabled` is high, and otherwise code 2.
- R9: A trap-conflict reset sets only the trap flag, and an illegal-operation reset sets only the illegal flag. Both select code 0 (reset vector), as do power-on, brown-out, pin, software and watchdog time-out.
- R10: A clock-failure trap changes no flag and selects code 1 (trap vector).
- R11: Same-cycle events take effect by priority, highest first: power-on, brown-out, pin, watchdog time-out, trap conflict, clock failure, illegal operation, software, watchdog wake, interrupt wake.
- R12: A `wr_en` in the same cycle as any event has no effect; the event's rule alone applies.
- R13: An event raises `resume_valid` with its code on the next cycle. The code stays stable while it is unacknowledged and no new event arrives. `resume_ack` with no event clears `resume_valid` on the next cycle, and a new event replaces a pending code.
- R14: While `rst_n` is low, `status` is 0x003 and `resume_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_por | input | 1 | Power-on pulse |
| ev_bor | input | 1 | Brown-out pulse |
| ev_pin | input | 1 | External reset pin pulse |
| ev_wdt_to | input | 1 | Watchdog time-out reset pulse |
| ev_trap | input | 1 | Trap-conflict reset pulse |
| ev_clk_fail | input | 1 | Clock-failure trap pulse |
| ev_illop | input | 1 | Illegal-operation reset pulse |
| ev_swr | input | 1 | Software reset pulse |
| ev_wdt_wake | input | 1 | Watchdog wake-from-sleep pulse |
| ev_int_wake | input | 1 | Interrupt wake-from-sleep pulse |
| core_sleep | input | 1 | Core was in sleep |
| core_idle | input | 1 | Core was in idle |
| int_enabled | input | 1 | Waking interrupt is enabled |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 9 | Software write data |
| status | output | 9 | Flag register |
| resume_valid | output | 1 | Resume code pending |
| resume_sel | output | 2 | 0 reset vector, 1 trap vector, 2 PC+2, 3 interrupt vector |
| resume_ack | input | 1 | Core takes the resume code |

## Verification
Two functions can land in the same cycle. A hardware event can coincide with a software write, and two or more event pulses can coincide with each other; a new event can also coincide with a resume acknowledge. Directed steps force each pairing: a write together with a pin, clock-failure or wake event, stacked pulses such as power-on with everything else, and an acknowledge together with a fresh event. A long random phase then sprinkles overlapping pulses and writes. A behavioural model in the bench applies the priority and the write rule, and the flags, valid bit and pending code are compared on every clock.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int NFLAG = 9;
  localparam int NEV   = 10;

  // flag bit positions
  localparam int F_POR = 0;
  localparam int F_BOR = 1;
  localparam int F_PIN = 2;
  localparam int F_SWR = 3;
  localparam int F_WDT = 4;
  localparam int F_SLP = 5;
  localparam int F_IDL = 6;
  localparam int F_TRP = 7;
  localparam int F_ILL = 8;

  // event indices, in priority order (0 = highest)
  localparam int EV_POR   = 0;
  localparam int EV_BOR   = 1;
  localparam int EV_PIN   = 2;
  localparam int EV_WDTO  = 3;
  localparam int EV_TRAP  = 4;
  localparam int EV_CFAIL = 5;
  localparam int EV_ILL   = 6;
  localparam int EV_SWR   = 7;
  localparam int EV_WWAKE = 8;
  localparam int EV_IWAKE = 9;

  localparam logic [NFLAG-1:0] POR_FLAGS = 9'h003;

  typedef enum logic [1:0] {
    RS_RESET = 2'd0,
    RS_TRAP  = 2'd1,
    RS_PC2   = 2'd2,
    RS_IVEC  = 2'd3
  } rsel_e;
endpackage

// File: rtl/rcs_arbiter.sv
module rcs_arbiter #(
  parameter int N = 10
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic seen;

  always_comb begin
    gnt  = '0;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] & ~seen;
      seen   = seen | req[i];
    end
  end

  assign any = |req;
endmodule

// File: rtl/rcs_flag_next.sv
module rcs_flag_next
  import rcs_pkg::*;
(
  input  logic [NFLAG-1:0] cur,
  input  logic [NEV-1:0]   gnt,
  input  logic             any,
  input  logic             core_sleep,
  input  logic             core_idle,
  input  logic             wr_en,
  input  logic [NFLAG-1:0] wr_data,
  output logic [NFLAG-1:0] nxt,
  output logic             load
);
  always_comb begin
    nxt  = cur;
    load = any | wr_en;
    if (gnt[EV_POR]) begin
      nxt        = '0;
      nxt[F_POR] = 1'b1;
      nxt[F_BOR] = 1'b1;
    end else if (gnt[EV_BOR]) begin
      nxt[F_BOR] = 1'b1;
      nxt[F_POR] = 1'b0;
    end else if (gnt[EV_PIN]) begin
      nxt[F_PIN] = 1'b1;
      nxt[F_WDT] = 1'b0;
      nxt[F_SLP] = core_sleep;
      nxt[F_IDL] = core_idle;
      if (!(core_sleep || core_idle)) nxt[F_SWR] = 1'b0;
    end else if (gnt[EV_WDTO]) begin
      nxt[F_WDT] = 1'b1;
      nxt[F_PIN] = 1'b0;
      nxt[F_SWR] = 1'b0;
      nxt[F_IDL] = 1'b0;
      nxt[F_SLP] = 1'b0;
    end else if (gnt[EV_TRAP]) begin
      nxt[F_TRP] = 1'b1;
    end else if (gnt[EV_CFAIL]) begin
      nxt = cur;
    end else if (gnt[EV_ILL]) begin
      nxt[F_ILL] = 1'b1;
    end else if (gnt[EV_SWR]) begin
      nxt[F_SWR] = 1'b1;
      nxt[F_PIN] = 1'b0;
      nxt[F_WDT] = 1'b0;
      nxt[F_IDL] = 1'b0;
      nxt[F_SLP] = 1'b0;
    end else if (gnt[EV_WWAKE]) begin
      nxt[F_WDT] = 1'b1;
      nxt[F_SLP] = 1'b1;
    end else if (gnt[EV_IWAKE]) begin
      nxt[F_SLP] = 1'b1;
    end else if (wr_en) begin
      nxt = wr_data;
    end
  end
endmodule

// File: rtl/rcs_resume.sv
module rcs_resume
  import rcs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] gnt,
  input  logic           any,
  input  logic           int_enabled,
  input  logic           resume_ack,
  output logic           resume_valid,
  output logic [1:0]     resume_sel
);
  rsel_e sel_d, sel_q;
  logic  valid_d, valid_q;

  always_comb begin
    sel_d = sel_q;
    if (gnt[EV_CFAIL])      sel_d = RS_TRAP;
    else if (gnt[EV_WWAKE]) sel_d = RS_PC2;
    else if (gnt[EV_IWAKE]) sel_d = int_enabled ? RS_IVEC : RS_PC2;
    else if (any)           sel_d = RS_RESET;
    if (any)             valid_d = 1'b1;
    else if (resume_ack) valid_d = 1'b0;
    else                 valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= RS_RESET;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (any) sel_q <= sel_d;
    end
  end

  assign resume_valid = valid_q;
  assign resume_sel   = sel_q;

  AST_RESUME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_valid && !resume_ack && !any) |=> (resume_valid && $stable(resume_sel))) // R13
    else $error("resume code moved while pending");
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_ack && !any) |=> !resume_valid) // R13
    else $error("ack did not clear valid");
  AST_WDT_WAKE_PC2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[EV_WWAKE] |=> (resume_sel == RS_PC2)) // R7
    else $error("watchdog wake code wrong");
endmodule

// File: rtl/rcs_top.sv
module rcs_top
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_pin,
  input  logic             ev_wdt_to,
  input  logic             ev_trap,
  input  logic             ev_clk_fail,
  input  logic             ev_illop,
  input  logic             ev_swr,
  input  logic             ev_wdt_wake,
  input  logic             ev_int_wake,
  input  logic             core_sleep,
  input  logic             core_idle,
  input  logic             int_enabled,
  input  logic             wr_en,
  input  logic [NFLAG-1:0] wr_data,
  output logic [NFLAG-1:0] status,
  output logic             resume_valid,
  output logic [1:0]       resume_sel,
  input  logic             resume_ack
);
  logic [NEV-1:0]   req, gnt;
  logic             any, load;
  logic [NFLAG-1:0] flags_d, flags_q;

  always_comb begin
    req            = '0;
    req[EV_POR]    = ev_por;
    req[EV_BOR]    = ev_bor;
    req[EV_PIN]    = ev_pin;
    req[EV_WDTO]   = ev_wdt_to;
    req[EV_TRAP]   = ev_trap;
    req[EV_CFAIL]  = ev_clk_fail;
    req[EV_ILL]    = ev_illop;
    req[EV_SWR]    = ev_swr;
    req[EV_WWAKE]  = ev_wdt_wake;
    req[EV_IWAKE]  = ev_int_wake;
  end

  rcs_arbiter #(.N(NEV)) u_arb (.req(req), .gnt(gnt), .any(any));

  rcs_flag_next u_next (
    .cur(flags_q), .gnt(gnt), .any(any),
    .core_sleep(core_sleep), .core_idle(core_idle),
    .wr_en(wr_en), .wr_data(wr_data),
    .nxt(flags_d), .load(load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= POR_FLAGS;
    else if (load) flags_q <= flags_d;
  end

  rcs_resume u_res (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .any(any),
    .int_enabled(int_enabled), .resume_ack(resume_ack),
    .resume_valid(resume_valid), .resume_sel(resume_sel)
  );

  assign status = flags_q;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) // R11
    else $error("more than one event granted");
  AST_POR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> (status == POR_FLAGS)) // R2
    else $error("power-on flags wrong");
  AST_BOR_CLEARS_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor && !ev_por) |=> (status[F_BOR] && !status[F_POR])) // R3
    else $error("brown-out flags wrong");
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any) |=> (status == $past(wr_data))) // R1
    else $error("software write lost");
  AST_CFAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[EV_CFAIL] |=> ($stable(status) && resume_sel == RS_TRAP)) // R10
    else $error("clock failure changed flags");
endmodule

// File: tb/tb_rcs_top.sv
module tb_rcs_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] ev;
  logic       core_sleep, core_idle, int_enabled, wr_en, resume_ack;
  logic [8:0] wr_data;
  logic [8:0] status;
  logic       resume_valid;
  logic [1:0] resume_sel;

  int checks = 0;
  int failures = 0;
  int m_fl, m_v, m_s;

  always #4 clk = ~clk;

  rcs_top dut (
    .clk(clk), .rst_n(rst_n),
    .ev_por(ev[0]), .ev_bor(ev[1]), .ev_pin(ev[2]), .ev_wdt_to(ev[3]),
    .ev_trap(ev[4]), .ev_clk_fail(ev[5]), .ev_illop(ev[6]), .ev_swr(ev[7]),
    .ev_wdt_wake(ev[8]), .ev_int_wake(ev[9]),
    .core_sleep(core_sleep), .core_idle(core_idle), .int_enabled(int_enabled),
    .wr_en(wr_en), .wr_data(wr_data), .status(status),
    .resume_valid(resume_valid), .resume_sel(resume_sel), .resume_ack(resume_ack)
  );

  // flag mask helpers: 0 por,1 bor,2 pin,3 swr,4 wdt,5 sleep,6 idle,7 trap,8 ill
  function automatic int setb(int v, int b, int on);
    return on ? (v | (1 << b)) : (v & ~(1 << b));
  endfunction

  task automatic model_update();
    int first = -1;
    for (int i = 9; i >= 0; i--) if (ev[i]) first = i;
    case (first)
      0: m_fl = 3;
      1: begin m_fl = setb(m_fl, 1, 1); m_fl = setb(m_fl, 0, 0); end
      2: begin
        m_fl = setb(m_fl, 2, 1); m_fl = setb(m_fl, 4, 0);
        m_fl = setb(m_fl, 5, core_sleep); m_fl = setb(m_fl, 6, core_idle);
        if (!core_sleep && !core_idle) m_fl = setb(m_fl, 3, 0);
      end
      3: m_fl = (m_fl & ~(32'h6C)) | 32'h10;
      4: m_fl = setb(m_fl, 7, 1);
      5: ;
      6: m_fl = setb(m_fl, 8, 1);
      7: m_fl = (m_fl & ~(32'h74)) | 32'h08;
      8: m_fl = m_fl | 32'h30;
      9: m_fl = m_fl | 32'h20;
      default: if (wr_en) m_fl = int'(wr_data);
    endcase
    if (first >= 0) begin
      m_v = 1;
      if (first == 5) m_s = 1;
      else if (first == 8) m_s = 2;
      else if (first == 9) m_s = int_enabled ? 3 : 2;
      else m_s = 0;
    end else if (resume_ack) m_v = 0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(status) != m_fl) begin
      failures++;
      $display("FAIL %s status actual=%03h expected=%03h", tag, status, m_fl[8:0]);
    end
    checks++;
    if (int'(resume_valid) != m_v) begin
      failures++;
      $display("FAIL %s resume_valid actual=%0d expected=%0d", tag, resume_valid, m_v);
    end
    if (m_v == 1) begin
      checks++;
      if (int'(resume_sel) != m_s) begin
        failures++;
        $display("FAIL %s resume_sel actual=%0d expected=%0d", tag, resume_sel, m_s);
      end
    end
  endtask

  task automatic step(input string tag, input logic [9:0] e, input logic slp, input logic idl,
                      input logic ie, input logic we, input logic [8:0] wd, input logic ak);
    ev = e; core_sleep = slp; core_idle = idl; int_enabled = ie;
    wr_en = we; wr_data = wd; resume_ack = ak;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [8:0] wd);
    step(tag, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1, wd, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev = '0; core_sleep = 0; core_idle = 0; int_enabled = 0;
    wr_en = 0; wr_data = '0; resume_ack = 0;
    m_fl = 3; m_v = 0; m_s = 0;
    repeat (3) @(negedge clk);
    compare("R14");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R14");

    wr("R1", 9'h000);
    wr("R1", 9'h1A5);
    wr("R1", 9'h05A);
    step("R2", 10'h001, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h1FC);
    step("R3", 10'h002, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h1FF);
    step("R4", 10'h004, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h1FF);
    step("R4", 10'h004, 1, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h0DB);
    step("R4", 10'h004, 0, 1, 0, 0, 9'h0, 0);
    wr("R1", 9'h1FF);
    step("R5", 10'h080, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h1FF);
    step("R6", 10'h008, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h000);
    step("R7", 10'h100, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h000);
    step("R8", 10'h200, 0, 0, 0, 0, 9'h0, 0);
    step("R8", 10'h200, 0, 0, 1, 0, 9'h0, 0);
    wr("R1", 9'h000);
    step("R9", 10'h010, 0, 0, 0, 0, 9'h0, 0);
    step("R9", 10'h040, 0, 0, 0, 0, 9'h0, 0);
    wr("R1", 9'h0A6);
    step("R10", 10'h020, 0, 0, 0, 0, 9'h0, 0);
    step("R11", 10'h3FF, 0, 0, 0, 0, 9'h0, 0);
    step("R11", 10'h3FE, 1, 1, 1, 0, 9'h0, 0);
    step("R11", 10'h3F8, 0, 0, 1, 0, 9'h0, 0);
    step("R11", 10'h3E0, 0, 0, 1, 0, 9'h0, 0);
    step("R11", 10'h300, 0, 0, 1, 0, 9'h0, 0);
    step("R12", 10'h004, 0, 0, 0, 1, 9'h1F0, 0);
    step("R12", 10'h020, 0, 0, 0, 1, 9'h000, 0);
    step("R12", 10'h200, 0, 0, 1, 1, 9'h0FF, 0);
    step("R13", 10'h000, 0, 0, 0, 0, 9'h0, 0);
    step("R13", 10'h000, 0, 0, 0, 0, 9'h0, 1);
    step("R13", 10'h000, 0, 0, 0, 0, 9'h0, 0);
    step("R13", 10'h020, 0, 0, 0, 0, 9'h0, 0);
    step("R13", 10'h100, 0, 0, 0, 0, 9'h0, 1);
    step("R13", 10'h000, 0, 0, 0, 0, 9'h0, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [9:0] e;
      e = '0;
      for (int b = 0; b < 10; b++) if (($urandom % 24) == 0) e[b] = 1'b1;
      step("R11", e, 1'($urandom), 1'($urandom), 1'($urandom),
           (($urandom % 3) == 0), 9'($urandom), (($urandom % 4) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule